// File: doc/BRIEF.md
# Systolic Montgomery Modular Multiplier

This block multiplies two operands modulo an odd modulus in Montgomery form. It returns T with T·R ≡ X·Y (mod N), where R = 2^(n+4·p) and n is the modulus width. The default p = 1 gives R = 2^(n+4). The work is spread over a one-dimensional chain of processing cells. Each cell owns one 4-bit digit of the multiplier Y and one 4-bit digit of the modulus N. Digits of the multiplicand X, and the quotient digits derived from them, travel one cell per clock from the least significant cell upwards. Partial-sum digits and a small carry word pass between neighbouring cells. Every path therefore spans a single cell, and the clock rate does not depend on the operand width.

The result is never reduced by a final subtraction. With R > 16N, any X and Y below 4N give a result below 2N. The output can therefore be fed straight back as an operand, or summed with another result without reduction. Conversion into Montgomery form (multiply by R² mod N) and out of it (multiply by 1) uses the same operation. The caller supplies the constant −N⁻¹ mod 16 with the operands.

A one-cycle start request loads the operands. A one-cycle done pulse follows after a fixed number of cycles, whatever the operand values and whether the operation is a square or a general product.

Top module: `mmm_systolic`

## Requirements
- R1: The result satisfies T·R ≡ X·Y (mod N) with R = 2^(4·(n/4+p)), which is 2^(n+4) for the default p = 1.
- R2: The result equals exactly (X·Y + m·N)/R, where m is the unique value in [0, R) that makes the numerator divisible by R. No final subtraction is applied.
- R3: For an odd N below 2^n and operands X, Y below 4N, the result is below 2N.
- R4: done rises for exactly one cycle, 3·(n/4+p)+4 clock edges after the edge that accepts start (3·n/4+7 for p = 1). busy is high from the accepting edge until the edge that raises done.
- R5: A square (X = Y) takes exactly the same number of cycles as a general product.
- R6: A start request while busy is high is ignored: neither the running result nor its done timing changes.
- R7: After reset, busy, done and t_out are zero. t_out changes only at the edge that raises done and holds its value between done pulses.
- R8: A multiplication by X = 1 with Y below N, as used to leave Montgomery form, gives a result no greater than N.
- R9: Each quotient digit is formed from n_prime = −N⁻¹ mod 16 so that the least significant digit of each partial sum is zero before the shift.
- R10: A start request in the cycle where done is high is accepted, so operations can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request; operands are sampled when it is accepted |
| x_in | input | n+4·p | Multiplicand X, below 4N |
| y_in | input | n+4·p | Multiplier Y, below 4N |
| n_in | input | n | Odd modulus N |
| n_prime | input | 4 | −N⁻¹ mod 16 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: t_out is valid |
| t_out | output | n+4·p | Montgomery product, below 2N |

## Verification
The reference model puts the accepting edge at cycle 0 and then compares busy and done at the falling edge after every rising edge. It expects busy high through cycle 54 and done high only after edge 55, for n = 64. The result is compared once, in the cycle where done is high, against the exact quotient and against the congruence. t_out is checked again after idle cycles. A second start is injected mid-run, and the next request is placed in the done cycle itself, so that any shift in timing shows up as a mismatch in a specific cycle.

// File: rtl/mmm_pkg.sv
`timescale 1ns/1ps
package mmm_pkg;
    localparam int DIGIT_W = 4;
    localparam int CARRY_W = 5;
    localparam int SUM_W   = 9;

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [CARRY_W-1:0] carry_t;

    // Digit pair travelling upward through the chain with its valid flag.
    typedef struct packed {
        logic   v;
        digit_t x;
        digit_t m;
    } flow_t;

    function automatic logic [SUM_W-1:0] cell_sum(input digit_t t, input digit_t x,
                                                  input digit_t y, input digit_t m,
                                                  input digit_t n, input carry_t c);
        return SUM_W'(t) + SUM_W'(x) * SUM_W'(y) + SUM_W'(m) * SUM_W'(n) + SUM_W'(c);
    endfunction
endpackage

// File: rtl/mmm_ctrl.sv
`timescale 1ns/1ps
module mmm_ctrl
    import mmm_pkg::*;
#(
    parameter int LAT = 55,
    parameter int D   = 17,
    parameter int CW  = $clog2(LAT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          load,
    output logic          fin,
    output logic          feed_v,
    output logic [CW-1:0] cyc
);
    assign load   = start && !busy;
    assign fin    = busy && (cyc == CW'(LAT - 1));
    assign feed_v = busy && (cyc < CW'(2 * D)) && !cyc[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            cyc  <= '0;
        end else begin
            done <= fin;
            if (load) begin
                busy <= 1'b1;
                cyc  <= '0;
            end else if (fin) begin
                busy <= 1'b0;
            end else if (busy) begin
                cyc <= cyc + 1'b1;
            end
        end
    end

    // R6: a request during a run neither restarts nor stalls the count
    a_r6_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !fin) |=> (busy && cyc == $past(cyc) + 1'b1));

    // R4: done only follows the terminal count of a run
    a_r4_done_after_count: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(busy) && $past(cyc) == CW'(LAT - 1)));
endmodule

// File: rtl/mmm_cell.sv
`timescale 1ns/1ps
module mmm_cell
    import mmm_pkg::*;
#(
    parameter bit FIRST = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  flow_t  fin,
    input  digit_t yd,
    input  digit_t nd,
    input  digit_t np,
    input  digit_t tin,
    input  carry_t cin,
    output flow_t  fout,
    output digit_t tq,
    output carry_t cq
);
    digit_t           m_use;
    logic [SUM_W-1:0] sum;

    if (FIRST) begin : g_quot
        logic [7:0] part;
        logic [7:0] qprod;
        always_comb begin
            part  = 8'(tin) + 8'(fin.x) * 8'(yd);
            qprod = 8'(part[3:0]) * 8'(np);
            m_use = qprod[3:0];
        end

        // R9: the chosen quotient digit cancels the low digit
        a_r9_low_digit_cancels: assert property (@(posedge clk) disable iff (rst)
            fin.v |-> (sum[3:0] == 4'd0));
    end else begin : g_pass
        assign m_use = fin.m;
    end

    assign sum = cell_sum(tin, fin.x, yd, m_use, nd, cin);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tq   <= '0;
            cq   <= '0;
            fout <= '0;
        end else begin
            fout.v <= fin.v;
            fout.x <= fin.x;
            fout.m <= m_use;
            if (fin.v) begin
                tq <= sum[3:0];
                cq <= sum[SUM_W-1:4];
            end
        end
    end
endmodule

// File: rtl/mmm_systolic.sv
`timescale 1ns/1ps
module mmm_systolic
    import mmm_pkg::*;
#(
    parameter int N_BITS     = 64,
    parameter int PAD_DIGITS = 1,
    parameter int L          = N_BITS / DIGIT_W,
    parameter int D          = L + PAD_DIGITS,
    parameter int OW         = DIGIT_W * D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OW-1:0]     x_in,
    input  logic [OW-1:0]     y_in,
    input  logic [N_BITS-1:0] n_in,
    input  logic [3:0]        n_prime,
    output logic              busy,
    output logic              done,
    output logic [OW-1:0]     t_out
);
    localparam int C   = D + 2;
    localparam int LAT = 3 * D + 4;
    localparam int CW  = $clog2(LAT + 1);

    logic [OW-1:0]     x_r, y_r;
    logic [N_BITS-1:0] n_r;
    digit_t            np_r;
    logic              load, fin, feed_v;
    logic [CW-1:0]     cyc;
    flow_t             feed;
    flow_t             fl [C];
    digit_t            tq [C];
    carry_t            cq [C];
    logic [OW-1:0]     res;

    mmm_ctrl #(.LAT(LAT), .D(D), .CW(CW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .load(load), .fin(fin), .feed_v(feed_v), .cyc(cyc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            x_r  <= '0;
            y_r  <= '0;
            n_r  <= '0;
            np_r <= '0;
        end else if (load) begin
            x_r  <= x_in;
            y_r  <= y_in;
            n_r  <= n_in;
            np_r <= n_prime;
        end
    end

    always_comb begin
        feed   = '0;
        feed.v = feed_v;
        for (int k = 0; k < D; k++) begin
            if (cyc[CW-1:1] == (CW-1)'(k)) feed.x = x_r[DIGIT_W*k +: DIGIT_W];
        end
    end

    for (genvar j = 0; j < C; j++) begin : g_cell
        flow_t  fi;
        digit_t ti, yd, nd;
        carry_t ci;

        if (j == 0) begin : g_head
            assign fi = feed;
            assign ci = '0;
        end else begin : g_link
            assign fi = fl[j-1];
            assign ci = cq[j-1];
        end

        if (j == C - 1) begin : g_top
            assign ti = '0;
        end else begin : g_mid
            assign ti = tq[j+1];
        end

        if (j < D) begin : g_ydig
            assign yd = y_r[DIGIT_W*j +: DIGIT_W];
        end else begin : g_yzero
            assign yd = '0;
        end

        if (j < L) begin : g_ndig
            assign nd = n_r[DIGIT_W*j +: DIGIT_W];
        end else begin : g_nzero
            assign nd = '0;
        end

        mmm_cell #(.FIRST(j == 0)) u_cell (
            .clk(clk), .rst(rst), .clr(load), .fin(fi), .yd(yd), .nd(nd),
            .np(np_r), .tin(ti), .cin(ci), .fout(fl[j]), .tq(tq[j]), .cq(cq[j])
        );
    end

    // Result digit k sits in cell k+1 after the final shift.
    always_comb begin
        for (int k = 0; k < D; k++) res[DIGIT_W*k +: DIGIT_W] = tq[k+1];
    end

    always_ff @(posedge clk) begin
        if (rst)      t_out <= '0;
        else if (fin) t_out <= res;
    end

    // R2: nothing is left above the top result digit at the end of a run
    a_r2_top_cell_empty: assert property (@(posedge clk) disable iff (rst)
        fin |-> (tq[C-1] == '0 && cq[C-1] == '0));

    // R3: the delivered result stays below twice the modulus
    a_r3_below_2n: assert property (@(posedge clk) disable iff (rst)
        done |-> ((OW+1)'(t_out) < (OW+1)'({n_r, 1'b0})));

    // R7: the result holds between done pulses
    a_r7_result_holds: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(t_out));

    // R4: done is a single-cycle pulse
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: tb/tb_mmm_systolic.sv
`timescale 1ns/1ps
module tb_mmm_systolic;
    localparam int NB  = 64;
    localparam int D   = NB / 4 + 1;
    localparam int OW  = 4 * D;
    localparam int RB  = OW;
    localparam int LAT = 3 * (NB / 4) + 7;
    localparam int BW  = 224;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [OW-1:0] x_in, y_in;
    logic [NB-1:0] n_in;
    logic [3:0]    n_prime;
    logic          busy, done;
    logic [OW-1:0] t_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    mmm_systolic #(.N_BITS(NB)) dut (
        .clk(clk), .rst(rst), .start(start), .x_in(x_in), .y_in(y_in),
        .n_in(n_in), .n_prime(n_prime), .busy(busy), .done(done), .t_out(t_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [BW-1:0] rmask();
        return (BW'(1) << RB) - 1'b1;
    endfunction

    function automatic logic [BW-1:0] inv_r(input logic [BW-1:0] n);
        logic [BW-1:0] v = n;
        for (int i = 0; i < 8; i++) v = (v * (BW'(2) - n * v)) & rmask();
        return v;
    endfunction

    function automatic logic [3:0] nprime_of(input logic [BW-1:0] n);
        logic [BW-1:0] neg = (~inv_r(n) + 1'b1);
        return neg[3:0];
    endfunction

    function automatic logic [BW-1:0] mont_ref(input logic [BW-1:0] x, input logic [BW-1:0] y,
                                               input logic [BW-1:0] n);
        logic [BW-1:0] ninv = (~inv_r(n) + 1'b1) & rmask();
        logic [BW-1:0] m    = ((x * y) * ninv) & rmask();
        return (x * y + m * n) >> RB;
    endfunction

    function automatic logic [BW-1:0] rnd_mod(input logic [BW-1:0] lim);
        logic [BW-1:0] r = {$urandom, $urandom, $urandom, $urandom};
        return r % lim;
    endfunction

    function automatic logic [BW-1:0] rnd_n();
        logic [63:0] r = {$urandom, $urandom};
        return BW'(r | 64'h8000_0000_0000_0001);
    endfunction

    // Entered at a falling edge; leaves at the falling edge of the done cycle.
    task automatic run_op(input logic [BW-1:0] x, input logic [BW-1:0] y,
                          input logic [BW-1:0] n, input bit inject, input string tag);
        logic [BW-1:0] exp = mont_ref(x, y, n);
        logic [BW-1:0] act;
        x_in = x[OW-1:0]; y_in = y[OW-1:0]; n_in = n[NB-1:0];
        n_prime = nprime_of(n);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= LAT; k++) begin
            if (inject && k == 5) begin
                start = 1'b1; x_in = ~x_in; y_in = y_in ^ 68'h5; n_prime = ~n_prime;
            end
            if (inject && k == 6) start = 1'b0;
            @(posedge clk);
            @(negedge clk);
            chk(done == (k == LAT), tag, $sformatf("done at cycle %0d", k), BW'(done), BW'(k == LAT));
            chk(busy == (k < LAT), tag, $sformatf("busy at cycle %0d", k), BW'(busy), BW'(k < LAT));
        end
        act = BW'(t_out);
        chk(act == exp, tag, "R2 R9 exact result", act, exp);
        chk(((act << RB) % n) == ((x * y) % n), tag, "R1 congruence", (act << RB) % n, (x * y) % n);
        chk(act < (n << 1), tag, "R3 below 2N", act, n << 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [BW-1:0] n, a, b, held;
        rst = 1'b1; start = 1'b0; x_in = '0; y_in = '0; n_in = '0; n_prime = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && t_out == '0, "R7", "reset state", BW'({busy, done}), '0);

        // R4 general product
        n = rnd_n(); a = rnd_mod(n); b = rnd_mod(n);
        run_op(a, b, n, 1'b0, "R4");

        // R8 leaving Montgomery form
        n = rnd_n(); b = rnd_mod(n);
        run_op(BW'(1), b, n, 1'b0, "R8");
        chk(BW'(t_out) <= n, "R8", "result at most N", BW'(t_out), n);

        // R3 largest allowed operands
        n = rnd_n(); a = (n << 2) - 1'b1;
        run_op(a, a, n, 1'b0, "R3");

        // R5 square, same latency
        n = rnd_n(); a = rnd_mod(n << 1);
        run_op(a, a, n, 1'b0, "R5");

        // R6 start injected mid-run, then R10 accepted in the done cycle
        n = rnd_n(); a = rnd_mod(n << 2); b = rnd_mod(n << 2);
        run_op(a, b, n, 1'b1, "R6");
        n = rnd_n(); a = (n << 1) - 1'b1; b = rnd_mod(n << 1);
        run_op(a, b, n, 1'b0, "R10");

        // R7 result holds while idle
        held = BW'(t_out);
        repeat (6) @(negedge clk);
        chk(BW'(t_out) == held && !done, "R7", "held result while idle", BW'(t_out), held);

        // R2 zero multiplicand
        n = rnd_n(); b = rnd_mod(n << 2);
        run_op('0, b, n, 1'b0, "R2");

        for (int i = 0; i < 8; i++) begin
            n = rnd_n(); a = rnd_mod(n << 2); b = rnd_mod(n << 2);
            run_op(a, b, n, 1'b0, "R1");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule